// File: doc/BRIEF.md
# Strip Detector Zero Suppression Filter

This block sits between the readout pipeline of a silicon strip front end and an output FIFO. For every trigger it takes in one complete event: the raw ADC samples of several readout chips, each with its own channels, read out over several time samples. The event is kept in a local buffer. For each channel the block then forms a hit statistic T from four of its time samples and its calibrated pedestal. Only the channels whose T exceeds their own threshold are written to the FIFO, so the size of each event varies and noise-only channels are removed early.

Work runs in three phases: store, find and send. During find and send the input is refused, and a busy flag covers the whole event. Each hit channel produces one output word per time sample. A closing marker word carries the hit count and is always sent. Pedestal and threshold tables, produced by an earlier calibration run, are loaded through a small write port while the block is idle.

Top module: `zs_filter`

## Requirements
- R1: `in_ready` is high while idle and during the store phase. `busy` rises after the first accepted word. After the last word of an event, `in_ready` is low and `busy` is high until the end marker has been written.
- R2: For each channel, T = (adc[s1] − pedestal) + adc[s2] + adc[s3] + adc[s4], where sample indices start at 0 and the pedestal is the one for that chip and channel. Samples 0 and 5 do not enter T.
- R3: A channel is a hit only when T is strictly greater than its threshold. A T equal to the threshold is not a hit.
- R4: T is signed and 15 bits wide. A negative T, for example all samples 0 with a pedestal of 4095, never produces a hit.
- R5: Hit channels are sent in order of ascending chip, then ascending channel. Each sends N_SAMP words with sample index 0 to N_SAMP−1 in order. Non-hit channels send nothing.
- R6: A hit word is packed as chip [47:46], sample [45:43], channel [42:36], pedestal [35:24], ADC value [23:12], with zeros in [11:0]. `fifo_eoe` is low for hit words.
- R7: Every event ends with exactly one marker word. It has `fifo_eoe` high, the number of hit channels in the low bits of `fifo_data` and zeros above. It is sent even when there are no hits.
- R8: While `fifo_full` is high, `fifo_wr` stays low, the pending word is held, and no output word is lost or repeated.
- R9: A table write is `cfg_we` with `cfg_sel` 0 for pedestal or 1 for threshold, and `cfg_addr` = chip·N_CH + channel. Writes take effect only while idle. A write made while busy is ignored, and `cfg_err` goes high in the following cycle.
- R10: After reset, `busy`, `fifo_wr` and `cfg_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| in_adc | input | 12 | Raw ADC sample; order is chip, then sample, then channel |
| in_ready | output | 1 | Block accepts input |
| busy | output | 1 | An event is being processed |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 selects pedestal, 1 selects threshold |
| cfg_addr | input | $clog2(N_CHIPS·N_CH) | Table index chip·N_CH + channel |
| cfg_data | input | 12 | Table value |
| cfg_err | output | 1 | A write was rejected in the previous cycle |
| fifo_full | input | 1 | Downstream FIFO cannot accept |
| fifo_wr | output | 1 | Output word is written this cycle |
| fifo_eoe | output | 1 | Current word is the end-of-event marker |
| fifo_data | output | 48 | Output word |

## Verification
The bench builds the filter with 2 chips, 8 channels and 6 samples. At that size an event is 96 words, and every hit-mask bit, both chip indices and a full table load all fit in a few hundred cycles. The stimulus covers several patterns: a no-hit event whose largest pedestal drives T far negative, a pattern that sets T exactly at and one above each threshold, all-maximum samples under an irregular full pattern, and mixed events. One of the mixed events contains a rejected table write, and the event after it shows that the write left no trace.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam int ADC_W   = 12;
    localparam int T_W     = ADC_W + 3;
    localparam int WORD_W  = 48;
    localparam int FIRST_T = 1;
    localparam int LAST_T  = 4;

    typedef logic [ADC_W-1:0]        adc_t;
    typedef logic signed [T_W-1:0]   tsum_t;

    typedef struct packed {
        logic [1:0]  chip;
        logic [2:0]  samp;
        logic [6:0]  chan;
        adc_t        ped;
        adc_t        adc;
        logic [11:0] pad;
    } hit_word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STORE,
        PH_FIND,
        PH_SEND,
        PH_TAIL
    } phase_t;

    function automatic hit_word_t pack_hit(int unsigned chip, int unsigned samp,
                                           int unsigned chan, adc_t ped, adc_t adc);
        hit_word_t w;
        w.chip = 2'(chip);
        w.samp = 3'(samp);
        w.chan = 7'(chan);
        w.ped  = ped;
        w.adc  = adc;
        w.pad  = '0;
        return w;
    endfunction

endpackage

// File: rtl/zs_event_buf.sv
module zs_event_buf
    import zs_pkg::*;
#(
    parameter int DEPTH = 2304,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  adc_t          wdata,
    input  logic [AW-1:0] raddr,
    output adc_t          rdata
);

    adc_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH)); // R1

endmodule

// File: rtl/zs_cal_tables.sv
module zs_cal_tables
    import zs_pkg::*;
#(
    parameter int N_IDX = 384,
    localparam int IW   = $clog2(N_IDX)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          sel,
    input  logic [IW-1:0] waddr,
    input  adc_t          wdata,
    input  logic [IW-1:0] raddr,
    output adc_t          ped,
    output adc_t          thr
);

    adc_t ped_mem [N_IDX];
    adc_t thr_mem [N_IDX];

    always_ff @(posedge clk) begin
        if (we && !sel) ped_mem[waddr] <= wdata;
        if (we &&  sel) thr_mem[waddr] <= wdata;
    end

    assign ped = ped_mem[raddr];
    assign thr = thr_mem[raddr];

endmodule

// File: rtl/zs_hit_accum.sv
module zs_hit_accum
    import zs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic first,
    input  logic last,
    input  adc_t adc,
    input  adc_t ped,
    input  adc_t thr,
    output logic hit
);

    tsum_t acc;
    tsum_t sum_nx;

    always_comb begin
        if (first) sum_nx = $signed({3'b000, adc}) - $signed({3'b000, ped});
        else       sum_nx = acc + $signed({3'b000, adc});
    end

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= sum_nx;
    end

    assign hit = en && last && (sum_nx > $signed({3'b000, thr}));

    AST_HIT_NONNEG: assert property (@(posedge clk) disable iff (rst)
        hit |-> !sum_nx[T_W-1]); // R4

endmodule

// File: rtl/zs_filter.sv
module zs_filter
    import zs_pkg::*;
#(
    parameter int N_CHIPS = 3,
    parameter int N_CH    = 128,
    parameter int N_SAMP  = 6,
    localparam int N_IDX  = N_CHIPS * N_CH,
    localparam int IW     = $clog2(N_IDX),
    localparam int DEPTH  = N_IDX * N_SAMP,
    localparam int AW     = $clog2(DEPTH),
    localparam int CHW    = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1,
    localparam int CNW    = $clog2(N_CH),
    localparam int SW     = $clog2(N_SAMP),
    localparam int HCW    = $clog2(N_IDX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADC_W-1:0]  in_adc,
    output logic              in_ready,
    output logic              busy,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IW-1:0]     cfg_addr,
    input  logic [ADC_W-1:0]  cfg_data,
    output logic              cfg_err,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic              fifo_eoe,
    output logic [WORD_W-1:0] fifo_data
);

    phase_t           ph;
    logic [CHW-1:0]   chip_i;
    logic [CNW-1:0]   ch_i;
    logic [SW-1:0]    samp_i;
    logic [N_IDX-1:0] hit_mask;
    logic [HCW-1:0]   hit_cnt;

    logic             accept, want_wr, acc_hit;
    logic             ch_last, chip_last, samp_last, end_scan;
    logic [CNW-1:0]   ch_adv;
    logic [CHW-1:0]   chip_adv;
    logic [IW-1:0]    idx;
    logic [AW-1:0]    baddr;
    adc_t             buf_rd, tbl_ped, tbl_thr;
    hit_word_t        hit_word;

    assign in_ready  = (ph == PH_IDLE) || (ph == PH_STORE);
    assign busy      = (ph != PH_IDLE);
    assign accept    = in_valid && in_ready;

    assign ch_last   = (int'(ch_i) == N_CH - 1);
    assign chip_last = (int'(chip_i) == N_CHIPS - 1);
    assign samp_last = (int'(samp_i) == N_SAMP - 1);
    assign end_scan  = ch_last && chip_last;
    assign ch_adv    = ch_last ? '0 : ch_i + 1'b1;
    assign chip_adv  = !ch_last ? chip_i : (chip_last ? '0 : chip_i + 1'b1);

    assign idx   = IW'(int'(chip_i) * N_CH + int'(ch_i));
    assign baddr = AW'((int'(chip_i) * N_SAMP + int'(samp_i)) * N_CH + int'(ch_i));

    zs_event_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .waddr (baddr),
        .wdata (in_adc),
        .raddr (baddr),
        .rdata (buf_rd)
    );

    zs_cal_tables #(.N_IDX(N_IDX)) u_tables (
        .clk   (clk),
        .we    (cfg_we && (ph == PH_IDLE)),
        .sel   (cfg_sel),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (idx),
        .ped   (tbl_ped),
        .thr   (tbl_thr)
    );

    zs_hit_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .en    (ph == PH_FIND),
        .first (int'(samp_i) == FIRST_T),
        .last  (int'(samp_i) == LAST_T),
        .adc   (buf_rd),
        .ped   (tbl_ped),
        .thr   (tbl_thr),
        .hit   (acc_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            chip_i   <= '0;
            ch_i     <= '0;
            samp_i   <= '0;
            hit_mask <= '0;
            hit_cnt  <= '0;
        end else begin
            case (ph)
                PH_IDLE, PH_STORE: begin
                    if (accept) begin
                        ph <= PH_STORE;
                        if (!ch_last) begin
                            ch_i <= ch_i + 1'b1;
                        end else begin
                            ch_i <= '0;
                            if (!samp_last) begin
                                samp_i <= samp_i + 1'b1;
                            end else if (!chip_last) begin
                                samp_i <= '0;
                                chip_i <= chip_i + 1'b1;
                            end else begin
                                samp_i <= SW'(FIRST_T);
                                chip_i <= '0;
                                ph     <= PH_FIND;
                            end
                        end
                    end
                end
                PH_FIND: begin
                    if (int'(samp_i) == LAST_T) begin
                        hit_mask[idx] <= acc_hit;
                        hit_cnt       <= hit_cnt + HCW'(acc_hit);
                        ch_i          <= ch_adv;
                        chip_i        <= chip_adv;
                        samp_i        <= end_scan ? '0 : SW'(FIRST_T);
                        if (end_scan) ph <= PH_SEND;
                    end else begin
                        samp_i <= samp_i + 1'b1;
                    end
                end
                PH_SEND: begin
                    if (!hit_mask[idx] || (!fifo_full && samp_last)) begin
                        samp_i <= '0;
                        ch_i   <= ch_adv;
                        chip_i <= chip_adv;
                        if (end_scan) ph <= PH_TAIL;
                    end else if (!fifo_full) begin
                        samp_i <= samp_i + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (!fifo_full) begin
                        ph       <= PH_IDLE;
                        hit_cnt  <= '0;
                        hit_mask <= '0;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= cfg_we && (ph != PH_IDLE);
    end

    assign hit_word  = pack_hit(int'(chip_i), int'(samp_i), int'(ch_i), tbl_ped, buf_rd);
    assign want_wr   = ((ph == PH_SEND) && hit_mask[idx]) || (ph == PH_TAIL);
    assign fifo_wr   = want_wr && !fifo_full;
    assign fifo_eoe  = (ph == PH_TAIL);
    assign fifo_data = fifo_eoe ? WORD_W'(hit_cnt) : hit_word;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (want_wr && fifo_full) |=> $stable(fifo_data)); // R8

    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fifo_wr && fifo_eoe)); // R7

    AST_TAIL_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && fifo_eoe) |-> (fifo_data[WORD_W-1:HCW] == '0)); // R7

    AST_OUT_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !in_ready); // R1

    AST_REJECT_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_we && busy)); // R9

    AST_SAMPLE_FIELD: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !fifo_eoe) |-> (int'(fifo_data[45:43]) < N_SAMP)); // R6

endmodule

// File: tb/zs_filter_tb.sv
module zs_filter_tb;
    import zs_pkg::*;

    localparam int NC  = 2;
    localparam int NCH = 8;
    localparam int NS  = 6;
    localparam int NI  = NC * NCH;
    localparam int IW  = $clog2(NI);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [ADC_W-1:0]  in_adc = '0;
    logic              in_ready, busy, cfg_err, fifo_wr, fifo_eoe;
    logic              cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [IW-1:0]     cfg_addr = '0;
    logic [ADC_W-1:0]  cfg_data = '0;
    logic              fifo_full = 1'b0;
    logic [WORD_W-1:0] fifo_data;

    int          total = 0;
    int          bad = 0;
    logic [48:0] exp_q[$];
    int          ped_m[NI];
    int          thr_m[NI];
    int          evt[NC][NS][NCH];
    bit          stall_en = 1'b0;
    string       cur_tag = "R5";

    always #4 clk = ~clk;

    zs_filter #(.N_CHIPS(NC), .N_CH(NCH), .N_SAMP(NS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_adc(in_adc),
        .in_ready(in_ready), .busy(busy), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_err(cfg_err),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_eoe(fifo_eoe),
        .fifo_data(fifo_data)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as words leave the block
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (fifo_full) chk(!fifo_wr, "R8", "write while full", longint'(fifo_wr), 0);
            if (fifo_wr) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected word", longint'({fifo_eoe, fifo_data}), 0);
                end else begin
                    logic [48:0] e;
                    e = exp_q.pop_front();
                    chk({fifo_eoe, fifo_data} == e, e[48] ? "R7" : cur_tag,
                        "output word", longint'({fifo_eoe, fifo_data}), longint'(e));
                end
            end
        end
    end

    // irregular full pattern, driven away from the clock edge
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            k++;
            fifo_full = stall_en && (((k % 3) == 0) || ((k % 7) == 2));
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic cfg_write(bit sel, int idx, int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = IW'(idx); cfg_data = ADC_W'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        chk(cfg_err == 1'b0, "R9", "idle write flagged", longint'(cfg_err), 0);
    endtask

    // reference model: T over samples 1..4, strict compare, chip/channel order
    task automatic model_push();
        int cnt = 0;
        for (int c = 0; c < NC; c++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                int i = c * NCH + ch;
                int t = (evt[c][1][ch] - ped_m[i]) + evt[c][2][ch] + evt[c][3][ch] + evt[c][4][ch];
                if (t > thr_m[i]) begin
                    cnt++;
                    for (int s = 0; s < NS; s++)
                        exp_q.push_back({1'b0, 2'(c), 3'(s), 7'(ch), 12'(ped_m[i]),
                                         12'(evt[c][s][ch]), 12'h000});
                end
            end
        end
        exp_q.push_back({1'b1, 48'(cnt)});
    endtask

    task automatic fill_zero();
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                for (int ch = 0; ch < NCH; ch++) evt[c][s][ch] = 0;
    endtask

    task automatic fill_edge();
        for (int c = 0; c < NC; c++)
            for (int ch = 0; ch < NCH; ch++) begin
                int i = c * NCH + ch;
                int a = thr_m[i] - 30 + (ch % 2);
                for (int s = 0; s < NS; s++) begin
                    if (i == 5)                 evt[c][s][ch] = 0;
                    else if (s == 0 || s == 5)  evt[c][s][ch] = 4000;
                    else if (s == 1)            evt[c][s][ch] = ped_m[i] + a;
                    else                        evt[c][s][ch] = 10;
                end
            end
    endtask

    task automatic fill_max();
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                for (int ch = 0; ch < NCH; ch++) evt[c][s][ch] = 4095;
    endtask

    task automatic fill_mix(int seed);
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                for (int ch = 0; ch < NCH; ch++) begin
                    int unsigned h = (c * 977 + s * 131 + ch * 59 + seed * 433) * 32'd2654435761;
                    int v = int'((h >> 9) & 32'hFFF);
                    if (((ch + c + seed) % 3) == 0) v = v & 32'h3F;
                    evt[c][s][ch] = v;
                end
    endtask

    task automatic run_event(string tag, bit poke);
        int w = 0;
        cur_tag = tag;
        model_push();
        chk(busy == 1'b0 && in_ready == 1'b1, "R1", "idle before event",
            longint'({busy, in_ready}), 1);
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                for (int ch = 0; ch < NCH; ch++) begin
                    in_valid = 1'b1;
                    in_adc   = ADC_W'(evt[c][s][ch]);
                    if (poke && w == 5) begin
                        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = '0; cfg_data = '0;
                    end
                    @(posedge clk); #1;
                    if (poke && w == 5) begin
                        cfg_we = 1'b0;
                        chk(cfg_err == 1'b1, "R9", "busy write not flagged", longint'(cfg_err), 1);
                    end
                    if (w == 0) chk(busy == 1'b1, "R1", "busy after first word", longint'(busy), 1);
                    w++;
                end
        in_valid = 1'b0;
        chk(in_ready == 1'b0 && busy == 1'b1, "R1", "input refused after event",
            longint'({in_ready, busy}), 1);
        while (busy) begin
            @(posedge clk); #1;
        end
        chk(exp_q.size() == 0, "R7", "words left unsent", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0 && fifo_wr == 1'b0 && cfg_err == 1'b0 && in_ready == 1'b1,
            "R10", "reset state", longint'({busy, fifo_wr, cfg_err, in_ready}), 1);
        rst = 1'b0;
        @(posedge clk); #1;

        for (int i = 0; i < NI; i++) begin
            ped_m[i] = (i == 5) ? 4095 : 200 + 7 * i;
            thr_m[i] = 40 + i;
            cfg_write(1'b0, i, ped_m[i]);
            cfg_write(1'b1, i, thr_m[i]);
        end

        fill_zero();   run_event("R4", 1'b0);   // all T negative, zero hits
        fill_edge();   run_event("R3", 1'b0);   // T == thr vs thr+1; samples 0,5 ignored
        stall_en = 1'b1;
        fill_max();    run_event("R8", 1'b0);   // every channel hit, stalled
        fill_mix(1);   run_event("R2", 1'b1);   // mixed pattern with rejected write
        stall_en = 1'b0;
        fill_edge();   run_event("R9", 1'b0);   // pedestal 0 unchanged by rejected write
        fill_mix(2);   run_event("R5", 1'b0);
        fill_mix(3);   run_event("R6", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule